// File: doc/BRIEF.md
# Oscillator Rate Trim Unit

This unit sits between a 32.768 kHz oscillator tick and the one-second strobe that feeds the timekeeping counters. It divides the oscillator down to seconds, groups the seconds into minutes, and groups the minutes into a repeating 64-minute trim cycle. A signed calibration setting chooses how many minutes at the start of each cycle are corrected. In a corrected minute only the opening second is changed. A positive setting shortens that second so the clock runs faster. A negative setting lengthens it so the clock runs slower. The two step sizes differ.

The calibration setting is written through a single write strobe with a 6-bit data word. Bit 5 is the sign: 1 speeds the clock up, 0 slows it down. Bits 4:0 hold the magnitude N, from 0 to 31, and N corrects minutes 0 through 2N-1 of the cycle. A new setting waits in a holding register and takes effect only when the next cycle starts, so one cycle never uses two settings. A separate enable turns on a test square wave at a nominal 512 Hz for measuring the crystal. The test wave is divided straight from the oscillator, so the calibration setting never changes its rate.

Top module: `rtc_rate_trim`

## Requirements
- R1: A second that is not corrected lasts exactly TICKS_PER_SEC oscillator ticks. The nominal value is 32768.
- R2: With sign bit calData[5]=1, the opening second of a corrected minute lasts TICKS_PER_SEC-POS_STEP ticks. The nominal POS_STEP is 256.
- R3: With sign bit calData[5]=0, the opening second of a corrected minute lasts TICKS_PER_SEC+NEG_STEP ticks. The nominal NEG_STEP is 128.
- R4: A magnitude N in calData[4:0] corrects only minutes 0 to 2N-1 of the cycle, and only their second 0. Minutes 62 and 63 are never corrected. N=0 corrects nothing, whatever the sign.
- R5: A minute is SEC_PER_MIN strobes. The cycle is 64 minutes and wraps from minute 63 to minute 0. The oscillator ticks in one whole cycle total 64·SEC_PER_MIN·TICKS_PER_SEC, plus or minus 2N times the step for that cycle's setting.
- R6: A written setting takes effect at the first second of the next cycle. The last write before that point wins. After reset the setting in use is zero.
- R7: A synchronous reset clears the divider and the second and minute counters, and it drives secTick and testOut low. The first second after reset is a full nominal second.
- R8: While testEnable is high, testOut toggles once every TEST_HALF oscillator ticks, with TEST_HALF nominally 32. While testEnable is low, testOut stays low.
- R9: The calibration setting does not change the toggle interval of testOut.
- R10: secTick is a one-clock pulse. The divider does not advance in clocks where oscTick is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| oscTick | input | 1 | One-clock enable per oscillator cycle |
| calWe | input | 1 | Write strobe for the calibration setting |
| calData | input | 6 | Bit 5 sign (1 = faster), bits 4:0 magnitude |
| testEnable | input | 1 | Enables the test square wave |
| secTick | output | 1 | One-clock strobe at the end of each corrected second |
| testOut | output | 1 | Test square wave, low when disabled |

## Verification
The hardest case to reach is the trim cycle boundary. That is where a pending setting becomes active, where minutes 62 and 63 must stay untouched, and where the per-cycle total closes. The bench uses a small configuration of 32 ticks per second and 4 seconds per minute, which brings seven full 64-minute cycles within reach. It writes a new setting in the middle of each cycle, so every boundary switches between settings with different signs and magnitudes (1, 6, 31, 0 and an overwritten 3/5). Each second's length is predicted from minute and second arithmetic and compared with the measured length. An oscillator gap is also inserted while the test wave runs.

// File: rtl/rtccal_pkg.sv
package rtccal_pkg;
  localparam int CAL_W = 6;

  typedef struct packed {
    logic       fast;
    logic [4:0] mag;
  } calSetting_t;

  typedef struct packed {
    logic trimOn;
    logic trimFast;
  } trimCmd_t;
endpackage

// File: rtl/rtccal_datapath.sv
module rtccal_datapath
  import rtccal_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter int POS_STEP      = 256,
  parameter int NEG_STEP      = 128,
  parameter int TEST_HALF     = 32
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     oscTick,
  input  logic     testEnable,
  input  trimCmd_t cmd,
  output logic     secWrap,
  output logic     secTick,
  output logic     testOut
);
  localparam int LONG_SEC = TICKS_PER_SEC + NEG_STEP;
  localparam int DIV_W    = $clog2(LONG_SEC + 1);
  localparam int TST_W    = $clog2(TEST_HALF + 1);

  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] secLimit;
  logic [TST_W-1:0] tstCnt;

  always_comb begin
    if (!cmd.trimOn)        secLimit = DIV_W'(TICKS_PER_SEC);
    else if (cmd.trimFast)  secLimit = DIV_W'(TICKS_PER_SEC - POS_STEP);
    else                    secLimit = DIV_W'(LONG_SEC);
  end

  assign secWrap = oscTick && (divCnt == secLimit - DIV_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      divCnt  <= '0;
      secTick <= 1'b0;
    end else begin
      secTick <= secWrap;
      if (secWrap)      divCnt <= '0;
      else if (oscTick) divCnt <= divCnt + DIV_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !testEnable) begin
      tstCnt  <= '0;
      testOut <= 1'b0;
    end else if (oscTick) begin
      if (tstCnt == TST_W'(TEST_HALF - 1)) begin
        tstCnt  <= '0;
        testOut <= ~testOut;
      end else begin
        tstCnt <= tstCnt + TST_W'(1);
      end
    end
  end

  assert_div_bound_R1: assert property (@(posedge clk) disable iff (rst)
    32'(divCnt) < LONG_SEC);
  assert_sec_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    secTick |=> !secTick);
  assert_div_idle_R10: assert property (@(posedge clk) disable iff (rst)
    (!oscTick && !secWrap) |=> $stable(divCnt));
  assert_test_low_R8: assert property (@(posedge clk) disable iff (rst)
    !testEnable |=> !testOut);
endmodule

// File: rtl/rtccal_control.sv
module rtccal_control
  import rtccal_pkg::*;
#(
  parameter int SEC_PER_MIN   = 60,
  parameter int MIN_PER_CYCLE = 64
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           calWe,
  input  logic [CAL_W-1:0] calData,
  input  logic           secWrap,
  output trimCmd_t       cmd
);
  localparam int SEC_W   = $clog2(SEC_PER_MIN);
  localparam int MIN_W   = $clog2(MIN_PER_CYCLE);
  localparam int MOD_MAX = MIN_PER_CYCLE - 2;

  logic [SEC_W-1:0] secCnt;
  logic [MIN_W-1:0] minCnt;
  calSetting_t      pendingCal, activeCal;
  logic             secLast, minLast, cycleWrap, inWindow;

  assign secLast   = secCnt == SEC_W'(SEC_PER_MIN - 1);
  assign minLast   = minCnt == MIN_W'(MIN_PER_CYCLE - 1);
  assign cycleWrap = secWrap && secLast && minLast;
  assign inWindow  = (int'(minCnt) < 2 * int'(activeCal.mag)) && (int'(minCnt) < MOD_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      secCnt     <= '0;
      minCnt     <= '0;
      pendingCal <= '0;
      activeCal  <= '0;
    end else begin
      if (calWe) pendingCal <= calSetting_t'(calData);
      if (secWrap) begin
        if (secLast) begin
          secCnt <= '0;
          if (minLast) begin
            minCnt    <= '0;
            activeCal <= pendingCal;
          end else begin
            minCnt <= minCnt + MIN_W'(1);
          end
        end else begin
          secCnt <= secCnt + SEC_W'(1);
        end
      end
    end
  end

  always_comb begin
    cmd.trimOn   = (secCnt == '0) && (activeCal.mag != '0) && inWindow;
    cmd.trimFast = activeCal.fast;
  end

  assert_setting_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !cycleWrap |=> $stable(activeCal));
  assert_minute_wrap_R5: assert property (@(posedge clk) disable iff (rst)
    cycleWrap |=> (minCnt == '0 && secCnt == '0));
  assert_tail_untouched_R4: assert property (@(posedge clk) disable iff (rst)
    cmd.trimOn |-> (int'(minCnt) < MOD_MAX && secCnt == '0));
  assert_minute_step_R5: assert property (@(posedge clk) disable iff (rst)
    (secWrap && secLast && !minLast) |=> (minCnt == $past(minCnt) + MIN_W'(1)));
endmodule

// File: rtl/rtc_rate_trim.sv
module rtc_rate_trim
  import rtccal_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter int POS_STEP      = 256,
  parameter int NEG_STEP      = 128,
  parameter int SEC_PER_MIN   = 60,
  parameter int MIN_PER_CYCLE = 64,
  parameter int TEST_HALF     = 32
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       oscTick,
  input  logic       calWe,
  input  logic [5:0] calData,
  input  logic       testEnable,
  output logic       secTick,
  output logic       testOut
);
  trimCmd_t cmd;
  logic     secWrap;

  rtccal_control #(
    .SEC_PER_MIN  (SEC_PER_MIN),
    .MIN_PER_CYCLE(MIN_PER_CYCLE)
  ) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .calWe  (calWe),
    .calData(calData),
    .secWrap(secWrap),
    .cmd    (cmd)
  );

  rtccal_datapath #(
    .TICKS_PER_SEC(TICKS_PER_SEC),
    .POS_STEP     (POS_STEP),
    .NEG_STEP     (NEG_STEP),
    .TEST_HALF    (TEST_HALF)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .oscTick   (oscTick),
    .testEnable(testEnable),
    .cmd       (cmd),
    .secWrap   (secWrap),
    .secTick   (secTick),
    .testOut   (testOut)
  );
endmodule

// File: tb/tb_rtc_rate_trim.sv
module tb_rtc_rate_trim;
  localparam int TK  = 32;
  localparam int PS  = 8;
  localparam int NG  = 4;
  localparam int SPM = 4;
  localparam int MPC = 64;
  localparam int HF  = 4;
  localparam int SPC = SPM * MPC;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst = 1'b1, oscTick = 1'b0, calWe = 1'b0, testEnable = 1'b0;
  logic [5:0] calData = '0;
  logic       secTick, testOut;

  rtc_rate_trim #(.TICKS_PER_SEC(TK), .POS_STEP(PS), .NEG_STEP(NG),
    .SEC_PER_MIN(SPM), .MIN_PER_CYCLE(MPC), .TEST_HALF(HF)) dut (
    .clk(clk), .rst(rst), .oscTick(oscTick), .calWe(calWe), .calData(calData),
    .testEnable(testEnable), .secTick(secTick), .testOut(testOut));

  int errs = 0, checks = 0;
  longint tickAcc = 0, lastMark = 0, cycStart = 0, tMark = 0;
  int secIdx = 0, wdog = 0;
  logic [5:0] mPend = '0, mAct = '0;
  logic prevSec = 1'b0, prevT = 1'b0, prevEn = 1'b0, monOn = 1'b0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d (second %0d)", tag, act, exp, secIdx);
    end
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    if (!rst && oscTick) tickAcc++;
    wdog++;
    if (wdog > 150000) begin
      errs++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", wdog, 150000);
      finishRun();
    end
  end

  // Monitor: second lengths, cycle totals and the test wave.
  always @(negedge clk) begin
    if (monOn) begin
      if (secTick) begin
        int sec, mn, mag;
        bit md;
        longint len, exp;
        string tag;
        chk(!prevSec, "R10 pulse width", prevSec, 0);
        len = tickAcc - lastMark; lastMark = tickAcc;
        sec = secIdx % SPM; mn = (secIdx / SPM) % MPC; mag = int'(mAct[4:0]);
        md  = (sec == 0) && (mn < 2 * mag) && (mn < MPC - 2);
        exp = md ? (mAct[5] ? TK - PS : TK + NG) : TK;
        if (md)                          tag = mAct[5] ? "R2 fast second" : "R3 slow second";
        else if (sec == 0 && mag != 0)   tag = "R4 outside window";
        else if (mPend != mAct)          tag = "R6 pending not yet active";
        else                             tag = "R1 nominal second";
        chk(len == exp, tag, len, exp);
        secIdx++;
        if (secIdx % SPC == 0) begin
          longint cexp;
          cexp = longint'(SPC) * TK + 2 * mag * (mAct[5] ? -PS : NG);
          chk(tickAcc - cycStart == cexp, "R5 cycle total", tickAcc - cycStart, cexp);
          cycStart = tickAcc;
          mAct = mPend;
        end
      end
      if (testEnable && !prevEn) tMark = tickAcc;
      if (prevEn && testOut != prevT) begin
        chk(tickAcc - tMark == HF, (mAct[4:0] != 0) ? "R9 test interval under trim" : "R8 test interval",
            tickAcc - tMark, HF);
        tMark = tickAcc;
      end
      if (!testEnable && !prevEn) chk(testOut == 1'b0, "R8 test low when off", testOut, 0);
    end
    prevSec = secTick; prevT = testOut; prevEn = testEnable;
  end

  task automatic writeCal(input logic [5:0] v);
    @(posedge clk); #1;
    calWe = 1'b1; calData = v; mPend = v;
    @(posedge clk); #1;
    calWe = 1'b0;
  endtask

  task automatic waitSec(input int n);
    while (secIdx < n) @(posedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(secTick == 1'b0, "R7 reset secTick", secTick, 0);
    chk(testOut == 1'b0, "R7 reset testOut", testOut, 0);
    rst = 1'b0; oscTick = 1'b1; monOn = 1'b1;
    waitSec(100);          writeCal(6'h21);  // +1
    waitSec(SPC + 100);    writeCal(6'h06);  // -6
    waitSec(2 * SPC + 10); @(posedge clk); #1; testEnable = 1'b1;
    waitSec(2 * SPC + 100); writeCal(6'h3F); // +31
    waitSec(3 * SPC + 50);
    @(posedge clk); #1; oscTick = 1'b0;
    repeat (20) begin
      @(negedge clk);
      chk(secTick == 1'b0, "R10 no strobe without ticks", secTick, 0);
    end
    @(posedge clk); #1; oscTick = 1'b1;
    waitSec(3 * SPC + 100); writeCal(6'h1F); // -31
    waitSec(4 * SPC + 100); writeCal(6'h20); // +0
    waitSec(5 * SPC + 100); writeCal(6'h23); // +3
    waitSec(5 * SPC + 150); writeCal(6'h05); // overwritten: -5
    waitSec(6 * SPC + 60);  @(posedge clk); #1; testEnable = 1'b0;
    waitSec(7 * SPC + 2);
    @(negedge clk);
    finishRun();
  end
endmodule